// File: doc/BRIEF.md
# Synchronous Serial Port Controller

A register-mapped serial port that moves words of 4 to 16 bits over a four-wire synchronous serial link, either as the clock-generating master or as a slave clocked from outside. Software configures it through five word registers on a simple select/write bus. It queues outgoing words by writing the data register and collects incoming words by reading that same register. Each direction has an 8-entry FIFO behind the data register.

As master, the serial clock is derived from the system clock by two stages: an even prescaler, then a divide-by-(rate+1) stage. Chip select is driven low for the length of each frame, and every word sent returns exactly one received word. As slave, the external clock, select and data are synchronised and oversampled by the system clock. A frame begins on each falling edge of select. The slave output driver can be disabled so that several slaves can share one return line. A loopback switch routes the transmit bit straight into the receiver.

Register indices on `addr_i`: 0 = frame control, 1 = port control, 2 = data, 3 = status, 4 = prescale.

Top module: `ssp_ctrl`

## Requirements
- R1: After reset the status register reads 0x0002, the prescale register reads 2, sclk_o is low and cs_no is high.
- R2: Frame control (index 0) reads back as written: bits [3:0] frame length minus one, [5:4] frame format (0 = SPI), bit 6 clock idle level, bit 7 clock phase, [15:8] rate value. Port control (index 1) holds bit 0 loopback, bit 1 enable, bit 2 slave select (1 = slave) and bit 3 slave output disable.
- R3: A write to the prescale register clears bit 0, and a value that becomes 0 is stored as 2.
- R4: A length field of 3 to 15 gives frames of field+1 bits, and fields 0 to 2 give 4-bit frames. Received words are right-justified with zero upper bits, and transmit bits above the frame length are ignored.
- R5: Data moves most significant bit first. The clock rests at the level of bit 6. With bit 7 clear, data is sampled on the leading clock edge; with bit 7 set, it is sampled on the trailing edge.
- R6: As master, one serial clock period lasts prescale × (rate + 1) system clocks.
- R7: Status bit 1 means the transmit FIFO is not full. Bit 2 means the receive FIFO is not empty. Bit 4 (busy) means a frame is in progress or transmit data is waiting. All other status bits read 0.
- R8: Both FIFOs hold 8 words. A data write to a full transmit FIFO is dropped. A data read from an empty receive FIFO returns 0 and changes nothing.
- R9: As master, each queued word produces exactly one frame and one received word, and cs_no is low during the frame.
- R10: With loopback set, the receiver takes the transmit bit and sd_i has no effect.
- R11: With enable clear, no frame starts, sclk_o rests at its idle level and FIFO contents are kept until enable is set again.
- R12: As slave, a frame starts on a falling edge of ss_ni and follows sclk_i in the configured mode. The next transmit word goes out on sd_o (0 if the FIFO is empty), and the received word is queued.
- R13: As slave, sd_oe_o is high only while ss_ni is low and output disable is clear. Reception still works with output disable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus access strobe, one cycle per access |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register index |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational from addr_i |
| sclk_o | output | 1 | Serial clock out (master) |
| cs_no | output | 1 | Chip select out, active low (master) |
| sclk_i | input | 1 | Serial clock in (slave) |
| ss_ni | input | 1 | Slave select in, active low |
| sd_i | input | 1 | Serial data in |
| sd_o | output | 1 | Serial data out |
| sd_oe_o | output | 1 | Output enable for sd_o |

## Verification
A register write takes effect at the clock edge of the access, so the bench reads it back from the next falling edge. Busy rises in the cycle after a data write. A received word is already in the receive FIFO in the first cycle busy reads 0, so the bench polls busy and then reads. The master clock period is measured between two rising sclk_o edges and must equal prescale × (rate + 1) cycles exactly. Slave inputs pass two synchroniser stages plus an edge detector, about three cycles of latency. The bench therefore holds each slave half-period for 8 cycles, drives new data on shift edges and samples sd_o just before each sample edge.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int unsigned DW = 16;

  localparam logic [2:0] REG_FRAME = 3'd0;
  localparam logic [2:0] REG_PORT  = 3'd1;
  localparam logic [2:0] REG_DATA  = 3'd2;
  localparam logic [2:0] REG_STAT  = 3'd3;
  localparam logic [2:0] REG_PSC   = 3'd4;

  typedef struct packed {
    logic [7:0] rate;
    logic       cpha;
    logic       cpol;
    logic [1:0] fmt;
    logic [3:0] len_m1;
  } frame_cfg_t;

  typedef struct packed {
    logic sod;
    logic slave;
    logic en;
    logic loop;
  } port_cfg_t;
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  // R8
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> (cnt_q == $past(cnt_q)));
  // R8
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> (empty_o && rp_q == $past(rp_q)));
endmodule

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
  parameter int unsigned PW = 8,
  parameter int unsigned SW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [PW-1:0] psc_i,
  input  logic [SW-1:0] rate_i,
  output logic          tick_o
);
  logic [PW-2:0] pre_q;
  logic [SW-1:0] div_q;
  logic          pre_last, div_last;

  // half period = (psc/2) * (rate+1) cycles
  assign pre_last = (pre_q == psc_i[PW-1:1] - 1'b1);
  assign div_last = (div_q == rate_i);
  assign tick_o   = run_i && pre_last && div_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      div_q <= '0;
    end else if (!run_i) begin
      pre_q <= '0;
      div_q <= '0;
    end else if (pre_last) begin
      pre_q <= '0;
      div_q <= div_last ? '0 : div_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = $clog2(2 * DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          slave_i,
  input  logic          cpol_i,
  input  logic          cpha_i,
  input  logic          loop_i,
  input  logic [CW-1:0] nbits_i,
  input  logic          tick_i,
  input  logic          sclk_s_i,
  input  logic          ss_s_i,
  input  logic          sd_s_i,
  input  logic          sd_i,
  input  logic          tx_avail_i,
  input  logic [DW-1:0] tx_data_i,
  output logic          tx_pop_o,
  output logic          active_o,
  output logic          sclk_o,
  output logic          sd_o,
  output logic          rx_push_o,
  output logic [DW-1:0] rx_data_o
);
  logic [DW-1:0] sr_q, rx_q, just, rx_next;
  logic [CW-1:0] ecnt_q;
  logic [CW:0]   last_idx;
  logic act_q, out_q, ph_q, sclk_prev_q, ss_prev_q;
  logic start, abort, edge_ev, sample, shift, last, din;

  assign start    = en_i && !act_q &&
                    (slave_i ? (ss_prev_q && !ss_s_i) : tx_avail_i);
  assign abort    = act_q && slave_i && ss_s_i;
  assign tx_pop_o = start && tx_avail_i;
  assign just     = (tx_avail_i ? tx_data_i : '0) << (CW'(DW) - nbits_i);
  assign last_idx = {nbits_i, 1'b0} - 1'b1;
  assign edge_ev  = act_q && (slave_i ? (sclk_s_i != sclk_prev_q) : tick_i);
  // even edge count = leading edge
  assign sample   = edge_ev && (!ecnt_q[0] ^ cpha_i);
  assign shift    = edge_ev && !(!ecnt_q[0] ^ cpha_i);
  assign last     = edge_ev && ({1'b0, ecnt_q} == last_idx);
  assign din      = loop_i ? out_q : (slave_i ? sd_s_i : sd_i);
  assign rx_next  = {rx_q[DW-2:0], din};

  assign rx_push_o = last && !abort;
  assign rx_data_o = sample ? rx_next : rx_q;
  assign active_o  = act_q;
  assign sclk_o    = cpol_i ^ ph_q;
  assign sd_o      = out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0; ph_q <= 1'b0; out_q <= 1'b0;
      ecnt_q <= '0; sr_q <= '0; rx_q <= '0;
      sclk_prev_q <= 1'b0; ss_prev_q <= 1'b1;
    end else begin
      sclk_prev_q <= sclk_s_i;
      ss_prev_q   <= ss_s_i;
      if (!en_i || abort) begin
        act_q <= 1'b0; ph_q <= 1'b0; ecnt_q <= '0;
      end else if (start) begin
        act_q  <= 1'b1;
        ecnt_q <= '0;
        rx_q   <= '0;
        if (cpha_i) begin
          sr_q <= just;
        end else begin
          out_q <= just[DW-1];
          sr_q  <= just << 1;
        end
      end else if (edge_ev) begin
        ecnt_q <= ecnt_q + 1'b1;
        if (!slave_i) ph_q <= !ph_q;
        if (sample) rx_q <= rx_next;
        if (shift) begin
          out_q <= sr_q[DW-1];
          sr_q  <= sr_q << 1;
        end
        if (last) begin
          act_q  <= 1'b0;
          ecnt_q <= '0;
        end
      end
    end
  end

  // R11
  off_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !act_q);
  // R5
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_q |-> (sclk_o == cpol_i));
  // R4
  edge_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> ({1'b0, ecnt_q} <= last_idx));
  // R9
  one_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |=> !act_q);
endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          wr_i,
  input  logic [2:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          sclk_o,
  output logic          cs_no,
  input  logic          sclk_i,
  input  logic          ss_ni,
  input  logic          sd_i,
  output logic          sd_o,
  output logic          sd_oe_o
);
  localparam int unsigned CW = $clog2(2 * DW);

  frame_cfg_t frm_q;
  port_cfg_t  prt_q;
  logic [7:0] psc_q;
  logic [2:0] sync1_q, sync2_q;
  logic       sclk_s, ss_s, sd_s;
  logic [CW-1:0] nbits;
  logic tx_push, rx_pop, tx_pop, rx_push, tick, active;
  logic tx_empty, tx_full, rx_empty, rx_full, busy;
  logic [DW-1:0] tx_head, rx_head, rx_word, status;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frm_q <= '0;
      prt_q <= '0;
      psc_q <= 8'd2;
    end else if (sel_i && wr_i) begin
      case (addr_i)
        REG_FRAME: frm_q <= frame_cfg_t'(wdata_i);
        REG_PORT:  prt_q <= port_cfg_t'(wdata_i[3:0]);
        REG_PSC:   psc_q <= (wdata_i[7:1] == '0) ? 8'd2 : {wdata_i[7:1], 1'b0};
        default: ;
      endcase
    end
  end

  // {sclk, ss, sd}
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 3'b010;
      sync2_q <= 3'b010;
    end else begin
      sync1_q <= {sclk_i, ss_ni, sd_i};
      sync2_q <= sync1_q;
    end
  end
  assign {sclk_s, ss_s, sd_s} = sync2_q;

  assign nbits   = (frm_q.len_m1 < 4'd3) ? CW'(4) : CW'(frm_q.len_m1) + 1'b1;
  assign tx_push = sel_i && wr_i && (addr_i == REG_DATA);
  assign rx_pop  = sel_i && !wr_i && (addr_i == REG_DATA);
  assign busy    = active || !tx_empty;
  assign status  = {11'd0, busy, 1'b0, !rx_empty, !tx_full, 1'b0};

  always_comb begin
    case (addr_i)
      REG_FRAME: rdata_o = frm_q;
      REG_PORT:  rdata_o = {12'd0, prt_q};
      REG_DATA:  rdata_o = rx_empty ? '0 : rx_head;
      REG_STAT:  rdata_o = status;
      REG_PSC:   rdata_o = {8'd0, psc_q};
      default:   rdata_o = '0;
    endcase
  end

  ssp_fifo #(.W(DW), .DEPTH(DEPTH)) tx_fifo_i (
    .clk_i, .rst_ni, .push_i(tx_push), .data_i(wdata_i), .pop_i(tx_pop),
    .data_o(tx_head), .empty_o(tx_empty), .full_o(tx_full));

  ssp_fifo #(.W(DW), .DEPTH(DEPTH)) rx_fifo_i (
    .clk_i, .rst_ni, .push_i(rx_push), .data_i(rx_word), .pop_i(rx_pop),
    .data_o(rx_head), .empty_o(rx_empty), .full_o(rx_full));

  ssp_clkgen #(.PW(8), .SW(8)) clkgen_i (
    .clk_i, .rst_ni, .run_i(active && !prt_q.slave), .psc_i(psc_q),
    .rate_i(frm_q.rate), .tick_o(tick));

  ssp_shifter #(.DW(DW), .CW(CW)) shifter_i (
    .clk_i, .rst_ni, .en_i(prt_q.en), .slave_i(prt_q.slave),
    .cpol_i(frm_q.cpol), .cpha_i(frm_q.cpha), .loop_i(prt_q.loop),
    .nbits_i(nbits), .tick_i(tick), .sclk_s_i(sclk_s), .ss_s_i(ss_s),
    .sd_s_i(sd_s), .sd_i, .tx_avail_i(!tx_empty), .tx_data_i(tx_head),
    .tx_pop_o(tx_pop), .active_o(active), .sclk_o, .sd_o,
    .rx_push_o(rx_push), .rx_data_o(rx_word));

  assign cs_no   = !(active && !prt_q.slave);
  assign sd_oe_o = prt_q.en && (!prt_q.slave || (!prt_q.sod && !ss_s));

  // R3
  psc_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psc_q[0] == 1'b0) && (psc_q != 8'd0));
  // R13
  sod_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prt_q.slave && prt_q.sod) |-> !sd_oe_o);
endmodule

// File: tb/ssp_ctrl_tb_top.sv
module ssp_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SH = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 1'b0, wr = 1'b0;
  logic [2:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic sclk, cs_n, sclk_in = 1'b0, ss_n = 1'b1, sd_drv = 1'b0, sd_out, sd_oe;
  logic ext_mode = 1'b0;
  wire  sd_in = ext_mode ? sd_out : sd_drv;
  int total = 0, bad = 0;
  longint cyc = 0;

  ssp_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .sclk_o(sclk), .cs_no(cs_n),
    .sclk_i(sclk_in), .ss_ni(ss_n), .sd_i(sd_in), .sd_o(sd_out), .sd_oe_o(sd_oe));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // {frame ctrl, prescale, tx word, expected rx}
  localparam logic [55:0] VEC [7] = '{
    {16'h0007, 8'd2, 16'h00A5, 16'h00A5},
    {16'h0187, 8'd2, 16'h003C, 16'h003C},
    {16'h004F, 8'd4, 16'hBEEF, 16'hBEEF},
    {16'h00C3, 8'd2, 16'h00F9, 16'h0009},
    {16'h020B, 8'd6, 16'hFABC, 16'h0ABC},
    {16'h0001, 8'd2, 16'h0037, 16'h0007},
    {16'h0084, 8'd2, 16'h0055, 16'h0015}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 1'b0;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd_reg(3'd3, s);
      if (!s[4]) return;
    end
  endtask

  // bench acts as master on sclk_in/ss_n/sd_drv
  task automatic slave_frame(input logic cpol, input logic cpha, input int n,
                             input logic [15:0] mval, output logic [15:0] got,
                             output logic oe);
    int bi;
    got = '0; oe = 1'b0;
    @(negedge clk); sclk_in = cpol; ss_n = 1'b0;
    bi = n - 1;
    if (!cpha) begin sd_drv = mval[bi]; bi--; end
    repeat (SH) @(negedge clk);
    for (int e = 0; e < 2*n; e++) begin
      logic smp;
      smp = (e % 2 == 0) ^ cpha;
      if (smp) begin got = {got[14:0], sd_out}; oe = sd_oe; end
      sclk_in = ~sclk_in;
      if (!smp && bi >= 0) begin sd_drv = mval[bi]; bi--; end
      repeat (SH) @(negedge clk);
    end
    ss_n = 1'b1;
    repeat (SH) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] r, got;
    logic oe;
    longint t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_reg(3'd3, r); chk("R1 status", r, 16'h0002);
    rd_reg(3'd4, r); chk("R1 prescale", r, 16'h0002);
    chk("R1 sclk/cs", {14'd0, sclk, cs_n}, 16'h0001);

    // R2 register readback
    wr_reg(3'd0, 16'h5AF3); rd_reg(3'd0, r); chk("R2 frame ctrl", r, 16'h5AF3);
    wr_reg(3'd1, 16'hFFF9); rd_reg(3'd1, r); chk("R2 port ctrl", r, 16'h0009);
    wr_reg(3'd1, 16'h0000);

    // R3 prescale
    wr_reg(3'd4, 16'h0007); rd_reg(3'd4, r); chk("R3 odd cleared", r, 16'h0006);
    wr_reg(3'd4, 16'h0001); rd_reg(3'd4, r); chk("R3 zero as two", r, 16'h0002);

    // R4 R5 R10 vector walk in loopback
    wr_reg(3'd1, 16'h0003);
    for (int i = 0; i < 7; i++) begin
      wr_reg(3'd0, VEC[i][55:40]);
      wr_reg(3'd4, {8'd0, VEC[i][39:32]});
      wr_reg(3'd2, VEC[i][31:16]);
      wait_idle();
      chk("R5 idle level", {15'd0, sclk}, {15'd0, VEC[i][46]});
      rd_reg(3'd2, r); chk("R4 R5 R10 vector rx", r, VEC[i][15:0]);
      rd_reg(3'd3, r); chk("R9 one word per frame", r, 16'h0002);
    end

    // R6 bit rate, R9 chip select
    wr_reg(3'd0, 16'h020F); wr_reg(3'd4, 16'h0004);
    wr_reg(3'd2, 16'h1234);
    @(posedge sclk); t0 = cyc;
    @(posedge sclk);
    chk("R6 period", 16'(cyc - t0), 16'd12);
    #1 chk("R9 cs low in frame", {15'd0, cs_n}, 16'h0000);
    wait_idle();
    chk("R9 cs high idle", {15'd0, cs_n}, 16'h0001);
    rd_reg(3'd2, r); chk("R9 rx word", r, 16'h1234);

    // external data path and loopback
    wr_reg(3'd0, 16'h0007); wr_reg(3'd4, 16'h0002);
    wr_reg(3'd1, 16'h0002); ext_mode = 1'b1;
    wr_reg(3'd2, 16'h0096); wait_idle();
    rd_reg(3'd2, r); chk("R9 external echo", r, 16'h0096);
    ext_mode = 1'b0; sd_drv = 1'b1;
    wr_reg(3'd2, 16'h0000); wait_idle();
    rd_reg(3'd2, r); chk("R9 external ones", r, 16'h00FF);
    wr_reg(3'd1, 16'h0003);
    wr_reg(3'd2, 16'h0000); wait_idle();
    rd_reg(3'd2, r); chk("R10 loopback ignores sd_i", r, 16'h0000);

    // R8 R11 fifo and disable
    wr_reg(3'd1, 16'h0001);
    for (int i = 1; i <= 9; i++) wr_reg(3'd2, 16'(i * 16'h11));
    rd_reg(3'd3, r); chk("R7 R8 full busy", r, 16'h0010);
    repeat (40) @(negedge clk);
    chk("R11 clock idle while off", {15'd0, sclk}, 16'h0000);
    rd_reg(3'd3, r); chk("R11 nothing shifted", r, 16'h0010);
    wr_reg(3'd1, 16'h0003);
    wait_idle();
    rd_reg(3'd3, r); chk("R7 rx ready", r, 16'h0006);
    for (int i = 1; i <= 8; i++) begin
      rd_reg(3'd2, r); chk("R8 R11 fifo order", r, 16'(i * 16'h11));
    end
    rd_reg(3'd2, r); chk("R8 empty read zero", r, 16'h0000);
    rd_reg(3'd3, r); chk("R8 status after empty read", r, 16'h0002);

    // R12 R13 slave
    wr_reg(3'd0, 16'h0087); wr_reg(3'd1, 16'h0006);
    chk("R13 oe low when deselected", {15'd0, sd_oe}, 16'h0000);
    wr_reg(3'd2, 16'h00C3);
    slave_frame(1'b0, 1'b1, 8, 16'h005A, got, oe);
    chk("R12 slave tx mode1", got, 16'h00C3);
    chk("R13 oe high when selected", {15'd0, oe}, 16'h0001);
    rd_reg(3'd2, r); chk("R12 slave rx mode1", r, 16'h005A);
    wr_reg(3'd0, 16'h0007);
    wr_reg(3'd2, 16'h0081);
    slave_frame(1'b0, 1'b0, 8, 16'h003C, got, oe);
    chk("R5 R12 slave tx mode0", got, 16'h0081);
    rd_reg(3'd2, r); chk("R12 slave rx mode0", r, 16'h003C);
    slave_frame(1'b0, 1'b0, 8, 16'h0011, got, oe);
    chk("R12 slave empty tx sends zero", got, 16'h0000);
    rd_reg(3'd2, r); chk("R12 slave rx", r, 16'h0011);
    wr_reg(3'd1, 16'h000E);
    slave_frame(1'b0, 1'b0, 8, 16'h007E, got, oe);
    chk("R13 oe low with disable", {15'd0, oe}, 16'h0000);
    rd_reg(3'd2, r); chk("R13 rx with disable", r, 16'h007E);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule